// File: doc/BRIEF.md
# Range-Match Translation Buffer with Round-Robin Refill

This block is a small, fully associative address translation cache. Each slot holds three things: an inclusive virtual window given as a first and a last address, a physical page number, and a packed set of protection attributes. Any slot whose window covers the probe address counts as a hit. The lookup port is purely combinational. It returns the index of the lowest-numbered covering slot, that slot's valid flag, its page number and its attributes. Deciding what those attributes permit is left to the logic outside the block.

Software fills a slot in two steps. An address-install command places a page-sized window and a physical page into a slot, and the slot stays invalid. A protection-install command then writes the attributes and marks the slot valid. Two further commands remove entries: one drops a single slot, the other empties the whole buffer. When an address-install finds no slot that already covers its address, it takes the slot under a round-robin pointer. A slot that has been wiped has its first address set to all ones and its last address set to zero, so it can never cover any address.

Top module: `rr_range_tlb`

## Requirements
- R1: The lookup outputs are combinational. `lk_hit` is 1 exactly when some slot has first <= `lk_addr` <= last, with both bounds included, and `lk_idx` is the lowest such slot. When `lk_hit` is 0, the outputs `lk_valid` and `lk_ppn` are 0.
- R2: Address-install (`cmd_op`=0) writes first = `cmd_addr` with its low 12 bits cleared, last = first + 0xFFF, and page number = `cmd_data[24:5]`. The slot it writes is left invalid.
- R3: Before filling, address-install invalidates every valid slot that covers `cmd_addr`. If at least one slot covers the address, the lowest such slot is the one rewritten and the pointer does not move.
- R4: When no slot covers the address, address-install fills the slot under the round-robin pointer. The pointer then advances by one and wraps from 15 to 0. Reset sets the pointer to 0.
- R5: Protection-install (`cmd_op`=1) writes into the lowest slot covering `cmd_addr` and sets that slot valid. The attribute outputs take these bits of `cmd_data`: `lk_aid`=[18:1], `lk_u`=[19], `lk_pl2`=[21:20], `lk_pl1`=[23:22], `lk_type`=[26:24], `lk_b`=[27], `lk_d`=[28], `lk_t`=[29].
- R6: If protection-install finds no covering slot, no slot changes, and `cmd_err` is 1 in the same cycle that `cmd_done` is 1.
- R7: Purge-one (`cmd_op`=2) wipes the lowest slot covering `cmd_addr`, but only when that slot is valid. An invalid covering slot stays as it was.
- R8: Purge-all (`cmd_op`=3) wipes every slot and leaves the round-robin pointer unchanged.
- R9: After reset, every slot is wiped, so no address hits, including 0xFFFFFFFF.
- R10: `cmd_done` is 1 for exactly the one cycle after each cycle in which `cmd_valid` is sampled high. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_addr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Some slot covers lk_addr |
| lk_idx | output | 4 | Lowest covering slot |
| lk_valid | output | 1 | That slot is valid |
| lk_ppn | output | 20 | Physical page number |
| lk_aid | output | 18 | Access identifier |
| lk_u | output | 1 | U attribute bit |
| lk_pl2 | output | 2 | Second privilege bound |
| lk_pl1 | output | 2 | First privilege bound |
| lk_type | output | 3 | Access-rights type |
| lk_b | output | 1 | Break attribute |
| lk_d | output | 1 | Dirty attribute |
| lk_t | output | 1 | Reference-trap attribute |
| cmd_valid | input | 1 | Execute a command this cycle |
| cmd_op | input | 2 | 0 addr-install, 1 prot-install, 2 purge-one, 3 purge-all |
| cmd_addr | input | 32 | Command virtual address |
| cmd_data | input | 32 | Command operand |
| cmd_done | output | 1 | Command finished (one cycle) |
| cmd_err | output | 1 | Protection-install found no slot |

## Verification
A command sampled at one rising edge takes effect at that edge. `cmd_done` and `cmd_err` are registered, so both are high during the following cycle. Lookup outputs depend only on `lk_addr` and the stored slots, so they are valid in the same cycle they are asked for. The bench drives commands and addresses on falling edges. It reads `cmd_done` and `cmd_err` at the falling edge after the accepting rising edge, and it checks a lookup one time unit after applying the address, by which point every slot write from the earlier edge has landed.

// File: rtl/rr_range_tlb.sv
module rr_range_tlb #(
  parameter int NENT      = 16,
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            lk_addr,
  output logic                     lk_hit,
  output logic [$clog2(NENT)-1:0]  lk_idx,
  output logic                     lk_valid,
  output logic [19:0]              lk_ppn,
  output logic [17:0]              lk_aid,
  output logic                     lk_u,
  output logic [1:0]               lk_pl2,
  output logic [1:0]               lk_pl1,
  output logic [2:0]               lk_type,
  output logic                     lk_b,
  output logic                     lk_d,
  output logic                     lk_t,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [31:0]              cmd_data,
  input  logic [AW-1:0]            cmd_addr,
  output logic                     cmd_done,
  output logic                     cmd_err
);
  localparam int IW     = $clog2(NENT);
  localparam int PPN_W  = 20;
  localparam int ATTR_W = 29;
  localparam logic [1:0] OP_INS = 2'd0, OP_PROT = 2'd1, OP_PONE = 2'd2, OP_PALL = 2'd3;

  logic [AW-1:0]     vb   [NENT];
  logic [AW-1:0]     ve   [NENT];
  logic [PPN_W-1:0]  ppn  [NENT];
  logic [ATTR_W-1:0] attr [NENT];
  logic [NENT-1:0]   vld;
  logic [IW-1:0]     ptr, ptr_nxt, cm_idx, ins_slot;
  logic [NENT-1:0]   lk_m, cm_m;
  logic              cm_hit;
  logic [ATTR_W-1:0] la;

  genvar g;
  generate
    for (g = 0; g < NENT; g++) begin : g_cmp
      assign lk_m[g] = (vb[g] <= lk_addr) && (lk_addr <= ve[g]);
      assign cm_m[g] = (vb[g] <= cmd_addr) && (cmd_addr <= ve[g]);
    end
  endgenerate

  always_comb begin
    lk_hit = 1'b0; lk_idx = '0; cm_hit = 1'b0; cm_idx = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (lk_m[i]) begin lk_hit = 1'b1; lk_idx = IW'(i); end
      if (cm_m[i]) begin cm_hit = 1'b1; cm_idx = IW'(i); end
    end
  end

  assign la       = lk_hit ? attr[lk_idx] : '0;
  assign lk_valid = lk_hit & vld[lk_idx];
  assign lk_ppn   = lk_hit ? ppn[lk_idx] : '0;
  assign lk_aid   = la[17:0];
  assign lk_u     = la[18];
  assign lk_pl2   = la[20:19];
  assign lk_pl1   = la[22:21];
  assign lk_type  = la[25:23];
  assign lk_b     = la[26];
  assign lk_d     = la[27];
  assign lk_t     = la[28];

  assign ptr_nxt  = (ptr == IW'(NENT - 1)) ? '0 : ptr + 1'b1;
  assign ins_slot = cm_hit ? cm_idx : ptr;

  logic unused_bits;
  assign unused_bits = ^{cmd_data[31:30], cmd_data[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        vb[i] <= '1; ve[i] <= '0; ppn[i] <= '0; attr[i] <= '0;
      end
      vld      <= '0;
      ptr      <= '0;
      cmd_done <= 1'b0;
      cmd_err  <= 1'b0;
    end else begin
      cmd_done <= cmd_valid;
      cmd_err  <= 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          OP_INS: begin
            for (int i = 0; i < NENT; i++)
              if (cm_m[i] && vld[i]) begin
                vb[i] <= '1; ve[i] <= '0; ppn[i] <= '0; attr[i] <= '0; vld[i] <= 1'b0;
              end
            if (!cm_hit) ptr <= ptr_nxt;
            vb[ins_slot]   <= {cmd_addr[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
            ve[ins_slot]   <= {cmd_addr[AW-1:PAGE_BITS], {PAGE_BITS{1'b1}}};
            ppn[ins_slot]  <= cmd_data[24:5];
            attr[ins_slot] <= '0;
            vld[ins_slot]  <= 1'b0;
          end
          OP_PROT: begin
            if (cm_hit) begin
              attr[cm_idx] <= cmd_data[29:1];
              vld[cm_idx]  <= 1'b1;
            end else begin
              cmd_err <= 1'b1;
            end
          end
          OP_PONE: begin
            if (cm_hit && vld[cm_idx]) begin
              vb[cm_idx] <= '1; ve[cm_idx] <= '0; ppn[cm_idx] <= '0;
              attr[cm_idx] <= '0; vld[cm_idx] <= 1'b0;
            end
          end
          default: begin
            for (int i = 0; i < NENT; i++) begin
              vb[i] <= '1; ve[i] <= '0; ppn[i] <= '0; attr[i] <= '0;
            end
            vld <= '0;
          end
        endcase
      end
    end
  end

  AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> cmd_done);  // R10
  AST_DONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !cmd_done);  // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> cmd_done);  // R6
  AST_PROT_MISS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PROT && !cm_hit) |=> cmd_err);  // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ptr == $past(ptr) || ptr == (($past(ptr) == IW'(NENT - 1)) ? '0 : $past(ptr) + 1'b1)));  // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op == OP_INS) |=> $stable(ptr));  // R8
  AST_PALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PALL) |=> (vld == '0));  // R8
  AST_LK_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!lk_valid && lk_ppn == '0));  // R1
endmodule

// File: tb/rr_range_tlb_tb.sv
module rr_range_tlb_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] lk_addr = '0, cmd_addr = '0, cmd_data = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic        lk_hit, lk_valid, lk_u, lk_b, lk_d, lk_t, cmd_done, cmd_err;
  logic [3:0]  lk_idx;
  logic [19:0] lk_ppn;
  logic [17:0] lk_aid;
  logic [1:0]  lk_pl2, lk_pl1;
  logic [2:0]  lk_type;
  int tests = 0, fails = 0;

  rr_range_tlb u_dut (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_valid(lk_valid), .lk_ppn(lk_ppn), .lk_aid(lk_aid), .lk_u(lk_u),
    .lk_pl2(lk_pl2), .lk_pl1(lk_pl1), .lk_type(lk_type), .lk_b(lk_b), .lk_d(lk_d),
    .lk_t(lk_t), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_addr(cmd_addr), .cmd_done(cmd_done), .cmd_err(cmd_err));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                     input logic exp_err);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 done pulse", cmd_done, 1'b1);
    chk("R6 err flag", cmd_err, exp_err);
    @(negedge clk);
    chk("R10 done drops", cmd_done, 1'b0);
  endtask

  task automatic look(input string tag, input logic [31:0] a, input logic hit,
                      input logic [3:0] idx, input logic v, input logic [19:0] p);
    lk_addr = a;
    #1;
    chk(tag, {lk_hit, lk_idx, lk_valid, lk_ppn}, {hit, (hit ? idx : 4'd0), v, p});
  endtask

  task automatic t_reset;
    look("R9 reset miss low", 32'h0000_0000, 0, 0, 0, 0);
    look("R9 reset miss high", 32'hFFFF_FFFF, 0, 0, 0, 0);
    look("R9 reset miss mid", 32'h1234_5678, 0, 0, 0, 0);
  endtask

  task automatic t_insert;
    cmd(2'd0, 32'h1234_5678, 32'h000A_BCDE << 5, 0);
    look("R2 R1 begin inclusive", 32'h1234_5000, 1, 0, 0, 20'hABCDE);
    look("R2 R1 end inclusive", 32'h1234_5FFF, 1, 0, 0, 20'hABCDE);
    look("R1 above end", 32'h1234_6000, 0, 0, 0, 0);
    look("R1 below begin", 32'h1234_4FFF, 0, 0, 0, 0);
  endtask

  task automatic t_prot;
    logic [31:0] d;
    d = (32'h2AAAA << 1) | (32'd1 << 19) | (32'd2 << 20) | (32'd1 << 22) |
        (32'd5 << 24) | (32'd1 << 27) | (32'd1 << 29) | 32'hC000_0001;
    cmd(2'd1, 32'h1234_5ABC, d, 0);
    look("R5 valid set", 32'h1234_5000, 1, 0, 1, 20'hABCDE);
    chk("R5 fields", {lk_aid, lk_u, lk_pl2, lk_pl1, lk_type, lk_b, lk_d, lk_t},
        {18'h2AAAA, 1'b1, 2'd2, 2'd1, 3'd5, 1'b1, 1'b0, 1'b1});
  endtask

  task automatic t_prot_miss;
    cmd(2'd1, 32'h0000_7000, 32'h3FFF_FFFE, 1);
    look("R6 no new slot", 32'h0000_7000, 0, 0, 0, 0);
    look("R6 other slot kept", 32'h1234_5000, 1, 0, 1, 20'hABCDE);
    chk("R6 fields kept", {lk_aid, lk_type}, {18'h2AAAA, 3'd5});
  endtask

  task automatic t_rr;
    for (int k = 0; k < 16; k++)
      cmd(2'd0, 32'h4000_0000 + 32'(k) * 32'h1000, 32'(k + 16'h100) << 5, 0);
    for (int k = 0; k < 16; k++)
      look("R4 round-robin slot", 32'h4000_0000 + 32'(k) * 32'h1000, 1,
           4'((k + 1) % 16), 0, 20'(k + 16'h100));
    look("R4 wrap evicted slot 0", 32'h1234_5000, 0, 0, 0, 0);
  endtask

  task automatic t_reuse;
    cmd(2'd1, 32'h4000_3000, 32'd1 << 28, 0);
    look("R5 slot 4 valid", 32'h4000_3010, 1, 4, 1, 20'h103);
    cmd(2'd0, 32'h4000_3FF0, 32'h0005_5555 << 5, 0);
    look("R3 reuse invalidates", 32'h4000_3000, 1, 4, 0, 20'h55555);
    chk("R3 attrs cleared", lk_d, 1'b0);
    cmd(2'd0, 32'h5000_0000, 32'h0000_0777 << 5, 0);
    look("R3 R4 pointer held", 32'h5000_0000, 1, 1, 0, 20'h777);
    look("R4 old slot 1 gone", 32'h4000_0000, 0, 0, 0, 0);
  endtask

  task automatic t_purge_one;
    cmd(2'd1, 32'h4000_5000, 32'd1 << 27, 0);
    cmd(2'd2, 32'h4000_5123, 32'h0, 0);
    look("R7 valid purged", 32'h4000_5000, 0, 0, 0, 0);
    cmd(2'd2, 32'h4000_7000, 32'h0, 0);
    look("R7 invalid kept", 32'h4000_7000, 1, 8, 0, 20'h107);
  endtask

  task automatic t_purge_all;
    cmd(2'd1, 32'h4000_9000, 32'd1 << 29, 0);
    cmd(2'd3, 32'h0, 32'h0, 0);
    look("R8 all gone a", 32'h4000_9000, 0, 0, 0, 0);
    look("R8 all gone b", 32'h5000_0000, 0, 0, 0, 0);
    look("R8 all gone c", 32'h4000_7000, 0, 0, 0, 0);
    cmd(2'd0, 32'h6000_0000, 32'h0000_0999 << 5, 0);
    look("R8 pointer kept", 32'h6000_0000, 1, 2, 0, 20'h999);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle done", cmd_done, 1'b0);
    t_reset;
    t_insert;
    t_prot;
    t_prot_miss;
    t_rr;
    t_reuse;
    t_purge_one;
    t_purge_all;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule